// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six status flags that follow an 8-bit or 16-bit ALU operation and keeps them in one flags register together with three control flags. The ALU supplies its operands, its result, its carry-out, the class of the operation (add, subtract, logic, shift/rotate), a width select and the last bit shifted out. The block turns these into carry, parity, auxiliary carry, zero, sign and overflow. Separate set and clear command vectors write the direction, interrupt-enable and trap control flags.

The status flags load only on a cycle that carries an update strobe. The control flags change only on an explicit command, and no ALU operation touches them. The packed flags word is driven straight from the flag registers. It reflects an update or command one clock after the cycle that presented it.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears every bit of the flags word on the next clock edge.
- R2: The carry flag (bit 0) takes `carry_out` for add (op_class 0) and subtract (op_class 1). It takes `shift_out` for shift/rotate (op_class 3). It is cleared for logic (op_class 2).
- R3: The overflow flag (bit 11) is 1 when an add or subtract overflows in two's complement at the selected width. It is cleared for logic and shift/rotate.
- R4: The sign flag (bit 7) equals the most significant bit of the result at the selected width.
- R5: The zero flag (bit 6) is 1 exactly when the result at the selected width is all zeros.
- R6: The auxiliary flag (bit 4) is the carry (add) or borrow (subtract) from bit 3 into bit 4. It is cleared for logic and shift/rotate.
- R7: The parity flag (bit 2) is 1 when the low 8 bits of the result hold an even number of ones.
- R8: With `wide_sel` = 0 only bits 7:0 of the operands and the result are used, and the upper bits have no effect. With `wide_sel` = 1 all 16 bits are used.
- R9: The status flags load one clock after a cycle with `upd_valid` = 1. They hold their values while `upd_valid` = 0.
- R10: Control-command bit 0 targets direction (bit 10), bit 1 targets interrupt enable (bit 9) and bit 2 targets trap (bit 8). A set bit makes its flag 1 and a clear bit makes it 0. Clear wins when both are given in the same cycle. Without a command the control flags hold, whatever operation is applied.
- R11: Bits 1, 3, 5 and 15:12 of the flags word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Load the status flags from this cycle's inputs |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift/rotate |
| wide_sel | input | 1 | 0 selects 8-bit, 1 selects 16-bit |
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand (the subtrahend for subtract) |
| alu_result | input | 16 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the top bit at the selected width |
| shift_out | input | 1 | Last bit shifted out |
| ctl_set | input | 3 | Control-flag set commands |
| ctl_clr | input | 3 | Control-flag clear commands |
| flags_word | output | 16 | Packed flags word |

## Verification
The bench targets the width boundaries. Examples are 0x7F+1 and 0x7FFF+1 for signed overflow, 0xFF+1 for a carry with a zero result, and 8-bit results whose upper byte carries junk. A design that watched the wrong top bit, or that looked at the upper byte in narrow mode, would report wrong sign, zero or overflow there. Other cases are a nibble carry and a nibble borrow that leave the top bits quiet, which catch an auxiliary flag taken from the wrong bit, and a parity case where the 16-bit result is nonzero but its low byte is empty. For shift and logic operations the bench raises `carry_out` while the carry flag must ignore it. It also sends set and clear to one control flag in the same cycle, checks that ALU updates leave the control flags alone, and checks that the status flags hold when no update is given.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_SHIFT = 2'd3
  } op_class_t;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  localparam int N_CTL = 3;
  localparam int CTL_DIR = 0;
  localparam int CTL_INT = 1;
  localparam int CTL_TRP = 2;
endpackage

// File: rtl/flag_status_calc.sv
module flag_status_calc
  import flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8,
  parameter int NIB_W    = 4
) (
  input  logic              wide_sel,
  input  op_class_t         op_class,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              carry_out,
  input  logic              shift_out,
  output status_t           status
);
  localparam int MSB_W = DATA_W - 1;
  localparam int MSB_N = NARROW_W - 1;

  logic sa, sb, sr;
  logic zero_n, zero_w;
  logic nib_cross;
  logic is_arith;

  always_comb begin
    sa = wide_sel ? opnd_a[MSB_W]     : opnd_a[MSB_N];
    sb = wide_sel ? opnd_b[MSB_W]     : opnd_b[MSB_N];
    sr = wide_sel ? alu_result[MSB_W] : alu_result[MSB_N];
  end

  assign zero_n    = (alu_result[NARROW_W-1:0] == '0);
  assign zero_w    = (alu_result == '0);
  assign nib_cross = opnd_a[NIB_W] ^ opnd_b[NIB_W] ^ alu_result[NIB_W];
  assign is_arith  = (op_class == OPC_ADD) || (op_class == OPC_SUB);

  always_comb begin
    status     = '0;
    status.sgn = sr;
    status.zro = wide_sel ? zero_w : zero_n;
    status.par = ~(^alu_result[PAR_W-1:0]);
    status.aux = is_arith & nib_cross;
    unique case (op_class)
      OPC_ADD: begin
        status.cry = carry_out;
        status.ovf = ~(sa ^ sb) & (sr ^ sa);
      end
      OPC_SUB: begin
        status.cry = carry_out;
        status.ovf = (sa ^ sb) & (sr ^ sa);
      end
      OPC_LOGIC: begin
        status.cry = 1'b0;
        status.ovf = 1'b0;
      end
      default: begin
        status.cry = shift_out;
        status.ovf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/flag_ctrl_reg.sv
module flag_ctrl_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_cmd,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             q[i] <= 1'b0;
      else if (clr_cmd[i]) q[i] <= 1'b0;
      else if (set_cmd[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [1:0]        op_class,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              carry_out,
  input  logic              shift_out,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic [WORD_W-1:0] flags_word
);
  status_t          next_st;
  status_t          st_q;
  logic [N_CTL-1:0] ctl_q;

  flag_status_calc #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_calc (
    .wide_sel  (wide_sel),
    .op_class  (op_class_t'(op_class)),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_result(alu_result),
    .carry_out (carry_out),
    .shift_out (shift_out),
    .status    (next_st)
  );

  always_ff @(posedge clk) begin
    if (rst)            st_q <= '0;
    else if (upd_valid) st_q <= next_st;
  end

  flag_ctrl_reg #(.N(N_CTL)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .set_cmd(ctl_set),
    .clr_cmd(ctl_clr),
    .q      (ctl_q)
  );

  always_comb begin
    flags_word         = '0;
    flags_word[POS_CF] = st_q.cry;
    flags_word[POS_PF] = st_q.par;
    flags_word[POS_AF] = st_q.aux;
    flags_word[POS_ZF] = st_q.zro;
    flags_word[POS_SF] = st_q.sgn;
    flags_word[POS_OF] = st_q.ovf;
    flags_word[POS_DF] = ctl_q[CTL_DIR];
    flags_word[POS_IF] = ctl_q[CTL_INT];
    flags_word[POS_TF] = ctl_q[CTL_TRP];
  end
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        upd_valid,
  input logic [1:0]  op_class,
  input logic        wide_sel,
  input logic [15:0] alu_result,
  input logic        shift_out,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] flags_word
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> flags_word == 16'h0);

  // R2
  shift_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && op_class == 2'd3) |=> flags_word[0] == $past(shift_out));

  // R3
  logic_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && op_class == 2'd2) |=> (!flags_word[11] && !flags_word[0]));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> flags_word[6] ==
      ($past(wide_sel) ? ($past(alu_result) == 16'h0) : ($past(alu_result[7:0]) == 8'h0)));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable({flags_word[11], flags_word[7:6], flags_word[4], flags_word[2], flags_word[0]}));

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_set == 3'b0 && ctl_clr == 3'b0) |=> $stable(flags_word[10:8]));

  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_clr[0] |=> !flags_word[10]);

  // R11
  unused_zero_chk: assert property (@(posedge clk)
    (flags_word[15:12] == 4'h0) && !flags_word[5] && !flags_word[3] && !flags_word[1]);
endmodule

bind status_flag_unit flag_unit_chk u_flag_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_valid (upd_valid),
  .op_class  (op_class),
  .wide_sel  (wide_sel),
  .alu_result(alu_result),
  .shift_out (shift_out),
  .ctl_set   (ctl_set),
  .ctl_clr   (ctl_clr),
  .flags_word(flags_word)
);

// File: tb/tb_status_flag_unit.sv
`timescale 1ns/1ps
module tb_status_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic        wide_sel = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_result = '0;
  logic        carry_out = 1'b0, shift_out = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] flags_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] model = '0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
    int          stamp;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  status_flag_unit dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .op_class(op_class),
    .wide_sel(wide_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_result(alu_result), .carry_out(carry_out), .shift_out(shift_out),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags_word(flags_word)
  );

  // monitor: compare once the item's clock edge has passed
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (flags_word !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, flags_word, it.exp);
      end
    end
  end

  function automatic logic [15:0] next_model(
      logic [15:0] cur, logic upd, logic [1:0] op, logic wd,
      logic [15:0] a, logic [15:0] b, logic [15:0] r,
      logic co, logic so, logic [2:0] st, logic [2:0] cl);
    logic [15:0] w;
    int va, vb, res, lo, hi;
    logic [2:0] ctl;
    w = cur;
    if (upd) begin
      w[0] = 0; w[2] = 0; w[4] = 0; w[6] = 0; w[7] = 0; w[11] = 0;
      va = wd ? int'($signed(a)) : int'($signed(a[7:0]));
      vb = wd ? int'($signed(b)) : int'($signed(b[7:0]));
      lo = wd ? -32768 : -128;
      hi = wd ? 32767 : 127;
      w[7] = wd ? r[15] : r[7];
      w[6] = wd ? (r == 16'h0) : (r[7:0] == 8'h0);
      w[2] = ($countones(r[7:0]) % 2) == 0;
      case (op)
        2'd0: begin
          res = va + vb; w[0] = co; w[11] = (res > hi) || (res < lo);
          w[4] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        end
        2'd1: begin
          res = va - vb; w[0] = co; w[11] = (res > hi) || (res < lo);
          w[4] = a[3:0] < b[3:0];
        end
        2'd2: ;
        default: w[0] = so;
      endcase
    end
    ctl = {w[8], w[9], w[10]};
    ctl = (ctl | st) & ~cl;
    w[10] = ctl[0]; w[9] = ctl[1]; w[8] = ctl[2];
    return w;
  endfunction

  task automatic step(input logic upd, input logic [1:0] op, input logic wd,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                      input logic co, input logic so,
                      input logic [2:0] st, input logic [2:0] cl, input string tag);
    item_t it;
    @(negedge clk);
    upd_valid = upd; op_class = op; wide_sel = wd; opnd_a = a; opnd_b = b;
    alu_result = r; carry_out = co; shift_out = so; ctl_set = st; ctl_clr = cl;
    model = next_model(model, upd, op, wd, a, b, r, co, so, st, cl);
    it.exp = model; it.tag = tag; it.stamp = cyc;
    sb_q.push_back(it);
  endtask

  // arithmetic step: bench forms the result and carry itself
  task automatic arith(input logic [1:0] op, input logic wd, input logic [15:0] a,
                       input logic [15:0] b, input logic [7:0] junk, input string tag);
    logic [16:0] full;
    logic [8:0]  nar;
    logic [15:0] r;
    logic co;
    if (wd) begin
      full = (op == 2'd0) ? ({1'b0, a} + {1'b0, b}) : ({1'b0, a} - {1'b0, b});
      r = full[15:0]; co = full[16];
    end else begin
      nar = (op == 2'd0) ? ({1'b0, a[7:0]} + {1'b0, b[7:0]}) : ({1'b0, a[7:0]} - {1'b0, b[7:0]});
      r = {junk, nar[7:0]}; co = nar[8];
    end
    step(1'b1, op, wd, a, b, r, co, 1'b0, 3'b0, 3'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b0, 3'b0, "idle R9");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    item_t it;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    it.exp = 16'h0; it.tag = "R1 reset state"; it.stamp = cyc;
    sb_q.push_back(it);
    // narrow arithmetic: R2 R3 R4 R5 R6 R7
    arith(2'd0, 1'b0, 16'h000F, 16'h0001, 8'h00, "R6 nibble carry 0F+01");
    arith(2'd0, 1'b0, 16'h007F, 16'h0001, 8'h00, "R3 R4 overflow 7F+01");
    arith(2'd0, 1'b0, 16'h00FF, 16'h0001, 8'h00, "R2 R5 carry and zero FF+01");
    arith(2'd1, 1'b0, 16'h0000, 16'h0001, 8'h00, "R6 R7 borrow 00-01");
    arith(2'd1, 1'b0, 16'h0080, 16'h0001, 8'h00, "R3 sub overflow 80-01");
    arith(2'd0, 1'b0, 16'h0012, 16'h0034, 8'h00, "R7 odd parity 12+34");
    // wide: R8
    arith(2'd0, 1'b1, 16'h7FFF, 16'h0001, 8'h00, "R8 R3 wide overflow");
    arith(2'd0, 1'b1, 16'h00FF, 16'h0001, 8'h00, "R7 R5 wide low byte empty");
    arith(2'd0, 1'b1, 16'hFFFF, 16'h0001, 8'h00, "R8 R2 wide carry zero");
    arith(2'd1, 1'b1, 16'h1000, 16'h0001, 8'h00, "R8 wide sub no overflow");
    // narrow with junk upper bits: R8
    arith(2'd0, 1'b0, 16'hC380, 16'h5A80, 8'hA5, "R8 junk upper 80+80");
    arith(2'd0, 1'b0, 16'hFF01, 16'hFF01, 8'hFF, "R8 junk upper 01+01");
    // logic and shift: R2 R3 R6
    step(1'b1, 2'd2, 1'b0, 16'h00FF, 16'h000F, 16'h000F, 1'b1, 1'b1, 3'b0, 3'b0, "R2 R3 logic clears CF OF");
    step(1'b1, 2'd3, 1'b0, 16'h0003, 16'h0000, 16'h0001, 1'b0, 1'b1, 3'b0, 3'b0, "R2 shift out 1");
    step(1'b1, 2'd3, 1'b1, 16'h8000, 16'h0000, 16'h8000, 1'b1, 1'b0, 3'b0, 3'b0, "R2 R6 shift ignores carry_out");
    // hold: R9
    arith(2'd0, 1'b0, 16'h007F, 16'h0001, 8'h00, "R9 load before hold");
    step(1'b0, 2'd3, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 3'b0, 3'b0, "R9 hold without update");
    idle(2);
    // control flags: R10 R11
    step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b111, 3'b000, "R10 set all control");
    arith(2'd1, 1'b0, 16'h0005, 16'h0005, 8'h00, "R10 op leaves control");
    step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b000, 3'b001, "R10 clear direction");
    step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b011, 3'b010, "R10 clear wins interrupt");
    step(1'b1, 2'd2, 1'b0, '0, '0, 16'h0000, 1'b1, 1'b0, 3'b000, 3'b000, "R10 R11 logic keeps control");
    step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b000, 3'b100, "R10 clear trap");
    // mid-run reset: R1
    step(1'b0, 2'd0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 3'b111, 3'b000, "R10 set before reset");
    @(negedge clk);
    rst = 1'b1; ctl_set = 3'b0;
    model = '0;
    it.exp = 16'h0; it.tag = "R1 mid-run reset"; it.stamp = cyc;
    sb_q.push_back(it);
    @(negedge clk);
    rst = 1'b0;
    arith(2'd0, 1'b0, 16'h0008, 16'h0008, 8'h00, "R6 R1 after reset 08+08");
    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard left %0d expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule